// File: doc/BRIEF.md
# Fixed-Frequency Voltage-Mode Pulse Modulator with Leading-Edge Blanking

This block drives the gate of a single power switch at a fixed switching frequency. A free-running sawtooth counter divides the system clock into switching periods; the default of 833 clocks at 100 MHz gives about 120 kHz. At the boundary of every period the gate is switched on, provided the supervisor enable is high. A set/reset pulse latch then holds the gate on until one of three terminations clears it: the width compare, a hard duty ceiling, or an over-current indication.

The pulse width comes from an unsigned error code. The code is captured once per period, at the boundary. At or below a knee value, the width sits at the duty ceiling (about 67 %). Above the knee, the width falls linearly with a programmable slope. It never goes below a minimum on-time of about 2 %.

The over-current input is not looked at during a short blanking window after turn-on. After that window it ends the pulse, and the gate stays off until the next period. A two-bit status output records which termination ended the most recent pulse. A one-clock strobe marks every period start.

Top module: `pwm_blank_mod`

## Requirements
- R1: `cycle_start_o` is high for exactly one clock, once every PERIOD clocks. The first strobe comes PERIOD clocks after reset is released.
- R2: With `en_i` high, `gate_o` rises in the same clock in which `cycle_start_o` is high, and at no other time.
- R3: For an error code E above KNEE, the pulse lasts MAX_ON − (E − KNEE)·SLOPE clocks, unless R5 applies.
- R4: The gate is never high for more than MAX_ON consecutive clocks. A pulse cut at that limit reports status 3.
- R5: A pulse that is not cut short by over-current or disable lasts at least MIN_ON clocks, whatever the error code.
- R6: For E ≤ KNEE (KNEE itself included), the pulse lasts exactly MAX_ON clocks.
- R7: `oc_i` has no effect during the first BLANK clocks of a pulse.
- R8: `oc_i` seen high in pulse clock BLANK+1 or later makes `gate_o` low in the next clock. The gate then stays low until the next period start, and the status reads 2.
- R9: The error code is captured only at the period boundary. A change during a pulse does not alter that pulse's width.
- R10: `gate_o` is low in any clock in which `en_i` is low. Once the gate has been killed, it only turns on again at a period start with `en_i` high. A pulse killed this way sets the status to 0.
- R11: The status encoding is 0 none/disabled, 1 width compare, 2 over-current, 3 duty ceiling. The status is valid in the first clock after the pulse has ended.
- R12: During reset, `gate_o`, `cycle_start_o` and `status_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Supervisor enable; low forces the gate off |
| err_i | input | ERR_W | Unsigned error code; larger gives a shorter pulse |
| oc_i | input | 1 | Over-current comparator output |
| gate_o | output | 1 | Gate enable for the power switch |
| cycle_start_o | output | 1 | One-clock strobe at each period start |
| status_o | output | 2 | Cause of the most recent pulse termination |

## Verification
The period strobe and the rising gate edge appear together, one clock after the counter's wrap edge. That edge is also where the error code is captured. A pulse therefore covers exactly its width in clocks, counted from the strobe clock.

An over-current sample or a width/ceiling match at one edge lowers the gate, and updates the status, in the clock that follows. Only the disable acts inside the same clock. The bench drives inputs shortly after each rising edge and compares the outputs at the falling edge against a behavioural integer model, so every result is checked in exactly the clock it is due. Directed sequences add checks on pulse lengths, strobe spacing, the blanking boundary, a mid-pulse code change and a mid-pulse disable.

// File: rtl/pwm_blank_pkg.sv
package pwm_blank_pkg;
  typedef enum logic [1:0] {
    END_NONE = 2'd0,
    END_CMP  = 2'd1,
    END_OC   = 2'd2,
    END_MAX  = 2'd3
  } end_cause_e;
endpackage

// File: rtl/pwm_saw_timer.sv
module pwm_saw_timer #(
  parameter int PERIOD = 833,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic clk,
  input  logic rst,
  output logic wrap_o
);
  logic [CW-1:0] cnt;

  assign wrap_o = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (wrap_o) cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/pwm_ontime_calc.sv
module pwm_ontime_calc #(
  parameter int ERR_W  = 8,
  parameter int AW     = 10,
  parameter int MAX_ON = 558,
  parameter int MIN_ON = 17,
  parameter int KNEE   = 40,
  parameter int SLOPE  = 3
) (
  input  logic [ERR_W-1:0] err_i,
  output logic [AW-1:0]    width_o
);
  int excess;
  int raw;

  always_comb begin
    excess = int'(err_i) - KNEE;
    if (excess < 0) excess = 0;
    raw = MAX_ON - excess * SLOPE;
    if (raw < MIN_ON) raw = MIN_ON;
    width_o = AW'(raw);
  end
endmodule

// File: rtl/pwm_gate_latch.sv
module pwm_gate_latch
  import pwm_blank_pkg::*;
#(
  parameter int AW     = 10,
  parameter int MAX_ON = 558,
  parameter int BLANK  = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          oc_i,
  input  logic          start_i,
  input  logic [AW-1:0] width_i,
  output logic          gate_o,
  output logic          cs_o,
  output logic [1:0]    status_o
);
  logic          gate_q;
  logic          cs_q;
  logic [AW-1:0] age;
  logic [AW-1:0] width_q;
  end_cause_e    cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= 1'b0;
      cs_q    <= 1'b0;
      age     <= '0;
      width_q <= '0;
      cause_q <= END_NONE;
    end else begin
      cs_q <= start_i;
      if (start_i && en_i) begin
        gate_q  <= 1'b1;
        age     <= AW'(1);
        width_q <= width_i;
      end else if (gate_q) begin
        if (!en_i) begin
          gate_q  <= 1'b0;
          cause_q <= END_NONE;
        end else if (oc_i && age > AW'(BLANK)) begin
          gate_q  <= 1'b0;
          cause_q <= END_OC;
        end else if (age >= AW'(MAX_ON)) begin
          gate_q  <= 1'b0;
          cause_q <= END_MAX;
        end else if (age >= width_q) begin
          gate_q  <= 1'b0;
          cause_q <= END_CMP;
        end else begin
          age <= age + AW'(1);
        end
      end
    end
  end

  assign gate_o   = gate_q & en_i;
  assign cs_o     = cs_q;
  assign status_o = cause_q;
endmodule

// File: rtl/pwm_blank_mod.sv
module pwm_blank_mod #(
  parameter int PERIOD = 833,
  parameter int ERR_W  = 8,
  parameter int MAX_ON = 558,
  parameter int MIN_ON = 17,
  parameter int KNEE   = 40,
  parameter int SLOPE  = 3,
  parameter int BLANK  = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             oc_i,
  output logic             gate_o,
  output logic             cycle_start_o,
  output logic [1:0]       status_o
);
  localparam int AW = $clog2(PERIOD + 1);

  logic          wrap;
  logic [AW-1:0] width;

  pwm_saw_timer #(.PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst(rst), .wrap_o(wrap)
  );

  pwm_ontime_calc #(
    .ERR_W(ERR_W), .AW(AW), .MAX_ON(MAX_ON), .MIN_ON(MIN_ON),
    .KNEE(KNEE), .SLOPE(SLOPE)
  ) u_calc (
    .err_i(err_i), .width_o(width)
  );

  pwm_gate_latch #(.AW(AW), .MAX_ON(MAX_ON), .BLANK(BLANK)) u_latch (
    .clk(clk), .rst(rst), .en_i(en_i), .oc_i(oc_i),
    .start_i(wrap), .width_i(width),
    .gate_o(gate_o), .cs_o(cycle_start_o), .status_o(status_o)
  );
endmodule

// File: rtl/pwm_blank_chk.sv
module pwm_blank_chk #(
  parameter int MAX_ON = 558,
  parameter int MIN_ON = 17,
  parameter int BLANK  = 18
) (
  input logic       clk,
  input logic       rst,
  input logic       en_i,
  input logic       oc_i,
  input logic       gate_o,
  input logic       cycle_start_o,
  input logic [1:0] status_o
);
  int hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)         hi_cnt <= 0;
    else if (gate_o) hi_cnt <= hi_cnt + 1;
    else             hi_cnt <= 0;
  end

  a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
    cycle_start_o |=> !cycle_start_o);

  a_r2_rise_with_start: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> cycle_start_o);

  a_r4_duty_ceiling: assert property (@(posedge clk) disable iff (rst)
    gate_o |-> hi_cnt < MAX_ON);

  a_r8_oc_after_blank: assert property (@(posedge clk) disable iff (rst)
    (gate_o && oc_i && hi_cnt >= BLANK) |=> !gate_o);

  a_r5_min_on: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate_o) && en_i && $past(en_i) && !$past(oc_i)) |-> ($past(hi_cnt) >= MIN_ON - 1));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!gate_o || cycle_start_o));

  a_r11_oc_status: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate_o) && en_i && $past(en_i) && $past(oc_i) && $past(hi_cnt) >= BLANK)
      |-> status_o == 2'd2);
endmodule

bind pwm_blank_mod pwm_blank_chk #(
  .MAX_ON(MAX_ON), .MIN_ON(MIN_ON), .BLANK(BLANK)
) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .oc_i(oc_i), .gate_o(gate_o),
  .cycle_start_o(cycle_start_o), .status_o(status_o)
);

// File: tb/pwm_blank_mod_tb.sv
module pwm_blank_mod_tb;
  localparam int P      = 60;
  localparam int EW     = 6;
  localparam int MAX_ON = 40;
  localparam int MIN_ON = 4;
  localparam int KNEE   = 10;
  localparam int SLOPE  = 2;
  localparam int BLANK  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic oc = 1'b0;
  logic [EW-1:0] err = '0;
  logic gate_o, cycle_start_o;
  logic [1:0] status_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  pwm_blank_mod #(
    .PERIOD(P), .ERR_W(EW), .MAX_ON(MAX_ON), .MIN_ON(MIN_ON),
    .KNEE(KNEE), .SLOPE(SLOPE), .BLANK(BLANK)
  ) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .err_i(err), .oc_i(oc),
    .gate_o(gate_o), .cycle_start_o(cycle_start_o), .status_o(status_o)
  );

  function automatic int exp_width(int e);
    int w;
    if (e <= KNEE) w = MAX_ON;
    else w = MAX_ON - (e - KNEE) * SLOPE;
    if (w < MIN_ON) w = MIN_ON;
    return w;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int m_ph = 0, m_hi = 0, m_len = 0, m_st = 0;
  bit m_on = 0, m_cs = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_hi = 0; m_len = 0; m_st = 0; m_on = 0; m_cs = 0;
    end else begin
      bit boundary;
      boundary = (m_ph == P - 1);
      m_ph = boundary ? 0 : m_ph + 1;
      if (boundary && en) begin
        m_on = 1; m_hi = 1; m_len = exp_width(int'(err));
      end else if (m_on) begin
        if (!en) begin m_on = 0; m_st = 0; end
        else if (oc && m_hi > BLANK) begin m_on = 0; m_st = 2; end
        else if (m_hi >= MAX_ON) begin m_on = 0; m_st = 3; end
        else if (m_hi >= m_len) begin m_on = 0; m_st = 1; end
        else m_hi++;
      end
      m_cs = boundary;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 gate vs model", int'(gate_o), int'(m_on && en));
      chk("R1 strobe vs model", int'(cycle_start_o), int'(m_cs));
      chk("R11 status vs model", int'(status_o), m_st);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wait_start();
    @(negedge clk);
    while (!cycle_start_o) @(negedge clk);
  endtask

  task automatic measure(output int w);
    wait_start();
    w = 0;
    while (gate_o) begin w++; @(negedge clk); end
  endtask

  initial begin
    int w;
    int gap;
    repeat (3) @(negedge clk);
    chk("R12 reset gate", int'(gate_o), 0);
    chk("R12 reset strobe", int'(cycle_start_o), 0);
    chk("R12 reset status", int'(status_o), 0);
    @(posedge clk); #2 rst = 1'b0; en = 1'b1; err = 6'd3;

    measure(w); chk("R6 low code width", w, MAX_ON);
    chk("R4 ceiling status", int'(status_o), 3);
    err = 6'd10; measure(w); chk("R6 knee width", w, MAX_ON);
    err = 6'd11; measure(w); chk("R3 just above knee", w, exp_width(11));
    err = 6'd20; measure(w); chk("R3 mid code width", w, 20);
    chk("R11 compare status", int'(status_o), 1);
    err = 6'd27; measure(w); chk("R3 width at 27", w, 6);
    err = 6'd28; measure(w); chk("R5 floor reached", w, MIN_ON);
    err = 6'd63; measure(w); chk("R5 floor max code", w, MIN_ON);

    wait_start(); gap = 0;
    do begin @(negedge clk); gap++; end while (!cycle_start_o);
    chk("R1 strobe spacing", gap, P);

    // R9: code changes right after the pulse has started
    err = 6'd20; wait_start(); wait_start();
    err = 6'd3; w = 0;
    while (gate_o) begin w++; @(negedge clk); end
    chk("R9 mid-pulse code change", w, 20);
    err = 6'd20;

    // R7: over-current during the blanking window only
    wait_start(); oc = 1'b1;
    repeat (BLANK) @(posedge clk);
    #2 oc = 1'b0;
    w = BLANK;
    @(negedge clk);
    while (gate_o) begin w++; @(negedge clk); end
    chk("R7 blanked oc ignored", w, 20);

    // R8: over-current just after blanking
    wait_start();
    repeat (BLANK) @(posedge clk);
    #2 oc = 1'b1;
    @(negedge clk); chk("R8 still on in sample clock", int'(gate_o), 1);
    @(negedge clk); chk("R8 off after oc", int'(gate_o), 0);
    chk("R8 oc status", int'(status_o), 2);
    #12 oc = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 stays off", int'(gate_o), 0);

    // R10: disable in mid-pulse, re-enable in the same period
    wait_start();
    @(posedge clk); #2 en = 1'b0;
    @(negedge clk); chk("R10 immediate kill", int'(gate_o), 0);
    @(posedge clk); #2 en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 no restart", int'(gate_o), 0);
    chk("R10 status none", int'(status_o), 0);
    measure(w); chk("R10 resumes next period", w, 20);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule